// File: doc/BRIEF.md
# Local History Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken, working from that branch's own recent behaviour. A few address bits of the branch select one of a small set of per-branch history shift registers. The pattern held in that register, meaning the last outcomes of that branch alone, then picks one 2-bit saturating counter from a larger pattern table. The prediction is the upper bit of that counter.

A fetch stage presents an address on the predict port and gets a combinational taken or not-taken answer from the registered tables. When the branch resolves, the execute stage presents the address and real outcome on the update port. In that clock cycle the chosen counter moves one step toward the outcome, and the outcome is shifted into the branch's history register. Branches whose selecting bits match share one history register. The default sizes are 64 history registers and 10 history bits. A full-size instance raises `HIST_W` to 14, which gives 16K counters.

Top module: `lhp_top`

## Requirements
- R1: After reset every history register holds zero and every counter holds 1 (weakly not taken), so every address predicts not taken.
- R2: The history register is selected by address bits `[PC_LSB +: LHT_IDX_W]`; addresses that agree in those bits share one register, and others are independent.
- R3: `pred_taken` is bit 1 of the counter indexed by the current history of the predicted address, so it is 1 exactly when that counter is 2 or 3.
- R4: An update with `upd_taken`=1 raises the used counter by one, and a counter at 3 stays at 3.
- R5: An update with `upd_taken`=0 lowers the used counter by one, and a counter at 0 stays at 0.
- R6: An update shifts the history of the updated branch left by one bit, inserts the outcome at bit 0 (1 = taken) and drops the oldest bit.
- R7: The counter that is changed is the one indexed by the history value before that update's shift.
- R8: An update takes effect at the next rising clock edge. A prediction made in the same cycle sees the old tables.
- R9: While `upd_valid` is 0, `upd_pc` and `upd_taken` change nothing.
- R10: A counter moves at most one step per update, so a counter in a strong state needs two opposite outcomes before its prediction flips.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_pc | input | PC_W | Branch address to predict |
| pred_taken | output | 1 | 1 = predicted taken |
| upd_valid | input | 1 | Applies one resolved outcome at this edge |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The bench uses a small instance with 4 history registers and 3 history bits. It compares the prediction for all four registers against an arithmetic model after every step. A run of repeated taken outcomes drives the counters into saturation, and a run of repeated not-taken outcomes drives them to the floor; together they separate the clamp from a wrap-around. Alternating outcomes and a taken-taken-not-taken loop train counters that only the history pattern can tell apart, which shows whether the index is taken before or after the shift. A same-cycle predict, idle cycles with random update data, addresses that differ only in unused upper bits, and a long random mix check the timing, the ignored input and the sharing of history registers.

// File: rtl/lhp_pkg.sv
package lhp_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'd0,
        CTR_WEAK_NT   = 2'd1,
        CTR_WEAK_T    = 2'd2,
        CTR_STRONG_T  = 2'd3
    } ctr_e;

    // one saturating step toward the resolved outcome
    function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
        logic [1:0] nxt;
        if (taken) nxt = (cur == CTR_STRONG_T)  ? cur : cur + 2'd1;
        else       nxt = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
        return nxt;
    endfunction

endpackage

// File: rtl/lhp_hist_table.sv
module lhp_hist_table #(
    parameter int IDX_W  = 6,
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [HIST_W-1:0] rd_a_hist,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [HIST_W-1:0] rd_b_hist,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_bit
);
    localparam int N = 1 << IDX_W;

    typedef struct packed {
        logic [N-1:0][HIST_W-1:0] hist;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.hist[wr_idx] = {st_q.hist[wr_idx][HIST_W-2:0], wr_bit};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_a_hist = st_q.hist[rd_a_idx];
    assign rd_b_hist = st_q.hist[rd_b_idx];

endmodule

// File: rtl/lhp_ctr_table.sv
module lhp_ctr_table
    import lhp_pkg::*;
#(
    parameter int HIST_W = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [HIST_W-1:0]             rd_idx,
    output logic [1:0]                    rd_ctr,
    input  logic                          upd_en,
    input  logic [HIST_W-1:0]             upd_idx,
    input  logic                          upd_taken,
    output logic [(1<<HIST_W)-1:0][1:0]   tab_o
);
    localparam int N = 1 << HIST_W;

    typedef struct packed {
        logic [N-1:0][1:0] ctr;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (upd_en) begin
            st_d.ctr[upd_idx] = ctr_step(st_q.ctr[upd_idx], upd_taken);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) st_q.ctr[i] <= CTR_WEAK_NT;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_ctr = st_q.ctr[rd_idx];
    assign tab_o  = st_q.ctr;

endmodule

// File: rtl/lhp_top.sv
module lhp_top #(
    parameter int PC_W      = 32,
    parameter int PC_LSB    = 2,
    parameter int LHT_IDX_W = 6,
    parameter int HIST_W    = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);
    localparam int PHT_N = 1 << HIST_W;

    logic [LHT_IDX_W-1:0]      pred_idx, upd_idx;
    logic [HIST_W-1:0]         pred_hist, upd_hist;
    logic [1:0]                pred_ctr;
    logic [PHT_N-1:0][1:0]     ctr_tab;
    logic                      unused_pc_bits;

    assign pred_idx       = pred_pc[PC_LSB +: LHT_IDX_W];
    assign upd_idx        = upd_pc[PC_LSB +: LHT_IDX_W];
    assign unused_pc_bits = ^{pred_pc, upd_pc};

    lhp_hist_table #(
        .IDX_W  (LHT_IDX_W),
        .HIST_W (HIST_W)
    ) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_idx  (pred_idx),
        .rd_a_hist (pred_hist),
        .rd_b_idx  (upd_idx),
        .rd_b_hist (upd_hist),
        .wr_en     (upd_valid),
        .wr_idx    (upd_idx),
        .wr_bit    (upd_taken)
    );

    // counter index is the history read before this edge's shift
    lhp_ctr_table #(
        .HIST_W (HIST_W)
    ) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (pred_hist),
        .rd_ctr    (pred_ctr),
        .upd_en    (upd_valid),
        .upd_idx   (upd_hist),
        .upd_taken (upd_taken),
        .tab_o     (ctr_tab)
    );

    assign pred_taken = pred_ctr[1];

endmodule

// File: rtl/lhp_checker.sv
module lhp_checker #(
    parameter int PC_W   = 32,
    parameter int HIST_W = 10
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [PC_W-1:0]             pred_pc,
    input logic                        pred_taken,
    input logic                        upd_valid,
    input logic [PC_W-1:0]             upd_pc,
    input logic                        upd_taken,
    input logic [HIST_W-1:0]           upd_hist,
    input logic [(1<<HIST_W)-1:0][1:0] ctr_tab
);

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> ($stable(pred_pc) -> $stable(pred_taken))); // R9

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> ($stable(upd_pc) ->
            upd_hist == {$past(upd_hist[HIST_W-2:0]), $past(upd_taken)})); // R6

    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && ctr_tab[upd_hist] == 2'd3)
            |=> ctr_tab[$past(upd_hist)] == 2'd3); // R4

    AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && ctr_tab[upd_hist] == 2'd0)
            |=> ctr_tab[$past(upd_hist)] == 2'd0); // R5

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=>
            ((int'(ctr_tab[$past(upd_hist)]) - int'($past(ctr_tab[upd_hist])) <= 1) &&
             (int'(ctr_tab[$past(upd_hist)]) - int'($past(ctr_tab[upd_hist])) >= -1))); // R10

endmodule

bind lhp_top lhp_checker #(
    .PC_W   (PC_W),
    .HIST_W (HIST_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pred_pc    (pred_pc),
    .pred_taken (pred_taken),
    .upd_valid  (upd_valid),
    .upd_pc     (upd_pc),
    .upd_taken  (upd_taken),
    .upd_hist   (upd_hist),
    .ctr_tab    (ctr_tab)
);

// File: tb/test_lhp_top.sv
`timescale 1ns/100ps
module test_lhp_top;
    localparam int PC_W = 8;
    localparam int LSB  = 2;
    localparam int IW   = 2;
    localparam int HW   = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] pred_pc = '0;
    logic            pred_taken;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [HW-1:0] m_hist [1<<IW];
    logic [1:0]    m_ctr  [1<<HW];

    always #4 clk = ~clk;

    lhp_top #(.PC_W(PC_W), .PC_LSB(LSB), .LHT_IDX_W(IW), .HIST_W(HW)) i_lhp_top (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
    );

    function automatic logic exp_pred(input logic [PC_W-1:0] pc);
        return m_ctr[m_hist[pc[LSB +: IW]]][1];
    endfunction

    task automatic model_upd(input logic [PC_W-1:0] pc, input logic t);
        logic [HW-1:0] h;
        h = m_hist[pc[LSB +: IW]];
        if (t) m_ctr[h] = (m_ctr[h] == 2'd3) ? 2'd3 : m_ctr[h] + 2'd1;
        else   m_ctr[h] = (m_ctr[h] == 2'd0) ? 2'd0 : m_ctr[h] - 2'd1;
        m_hist[pc[LSB +: IW]] = {h[HW-2:0], t};
    endtask

    task automatic chk(input string tag, input logic [PC_W-1:0] pc);
        logic e;
        pred_pc = pc;
        #0.5;
        e = exp_pred(pc);
        n_chk++;
        if (pred_taken !== e) begin
            n_fail++;
            $display("FAIL %s pc=%0h actual=%0b expected=%0b", tag, pc, pred_taken, e);
        end
    endtask

    // a random address whose selecting bits give slot s (R2: upper bits vary)
    function automatic logic [PC_W-1:0] slot_pc(input int s);
        logic [PC_W-1:0] p;
        p = PC_W'($urandom);
        p[LSB +: IW] = IW'(s);
        return p;
    endfunction

    task automatic step(input logic v, input logic [PC_W-1:0] pc, input logic t, input string tag);
        @(negedge clk);
        upd_valid = v;
        upd_pc    = pc;
        upd_taken = t;
        chk("R8 same-cycle", pc);
        @(negedge clk);
        if (v) model_upd(pc, t);
        upd_valid = 1'b0;
        upd_taken = $urandom_range(0, 1);
        upd_pc    = PC_W'($urandom);
        for (int s = 0; s < (1 << IW); s++) chk(tag, slot_pc(s));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < (1 << IW); i++) m_hist[i] = '0;
        for (int i = 0; i < (1 << HW); i++) m_ctr[i] = 2'd1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, every address not taken
        for (int p = 0; p < (1 << PC_W); p++) chk("R1 reset", PC_W'(p));

        // R4: repeated taken on slot 0 saturates high
        for (int k = 0; k < 8; k++) step(1'b1, slot_pc(0), 1'b1, "R4 taken run");
        // R10: one opposite outcome from strong state, then back
        step(1'b1, slot_pc(0), 1'b0, "R10 hysteresis");
        for (int k = 0; k < 3; k++) step(1'b1, slot_pc(0), 1'b1, "R10 hysteresis");
        // R5: repeated not taken on slot 1 saturates low
        for (int k = 0; k < 10; k++) step(1'b1, slot_pc(1), 1'b0, "R5 not-taken run");
        // R6: alternating outcomes on slot 2
        for (int k = 0; k < 12; k++) step(1'b1, slot_pc(2), k[0], "R6 alternating");
        // R7: taken-taken-not-taken loop on slot 3
        for (int k = 0; k < 15; k++) step(1'b1, slot_pc(3), (k % 3) != 2, "R7 loop");
        // R2: train through aliasing addresses of slot 1
        for (int k = 0; k < 8; k++) step(1'b1, slot_pc(1), 1'b1, "R2 alias");
        // R9: idle cycles with random update data
        for (int k = 0; k < 20; k++)
            step(1'b0, PC_W'($urandom), $urandom_range(0, 1), "R9 idle");
        // R3: long random mix
        for (int k = 0; k < 1500; k++)
            step(($urandom_range(0, 7) != 0), PC_W'($urandom), $urandom_range(0, 1), "R3 random");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule